// File: doc/BRIEF.md
# UART Transmitter with Completion Flags

This block is the transmit half of a UART. It has a one-byte holding register, a frame shifter and a status register. Software writes a byte over a small register bus. The byte waits in the holding register until the shifter is idle, then goes out as an 8N1 frame. The shifter advances on an external baud tick. Out-of-scope blocks provide that tick and the receiver.

Software polls two kinds of completion status. The first is a sticky completion event. It is set only when a frame ends with nothing queued behind it. Software clears it by writing a one, and an acknowledged interrupt also clears it. Once cleared, it stays cleared until another frame completes. The second is a level "transmitter empty" status. It is true whenever nothing is queued or shifting, so code with no knowledge of past traffic can still tell that the line is quiet. A driver-enable output for a half-duplex RS485 transceiver is asserted while traffic is pending. It is released in the same cycle that the completion event is raised.

Top module: `uart_txc_ctrl`

## Requirements
- R1: After reset, the status byte reads with the queue-ready flag at 1, the empty flag at 1, the completion flag at 0 and the receive flag following `rx_valid_i`. After reset, `txd_o` is 1, `de_o` is 0 and the control byte is 0.
- R2: The register bus is decoded as follows:
  - Address 0: a write queues a data byte.
  - Address 1: a read returns the status byte. Bit 7 is receive-ready, bit 6 is transmit-complete, bit 5 is queue-ready and bit 4 is transmitter-empty. The other bits read 0.
  - Address 2: a read-write control byte. Bit 0 enables the completion interrupt, bit 1 the queue-ready interrupt, bit 2 the receive interrupt and bit 3 the RS485 driver enable.
  - Address 3 and reads of address 0 return 0.
- R3: The queue-ready flag is 1 exactly when the holding register is empty. A data write while it is 0 is ignored. A queued byte moves into the shifter on the first clock in which the shifter is idle, and the flag then returns to 1.
- R4: Each frame is made of a low start bit, 8 data bits sent LSB first and a high stop bit. Each bit lasts 16 baud ticks. `txd_o` is high when no frame is being shifted.
- R5: The transmit-complete flag is set in the cycle after the stop bit's last tick, and only when no byte is waiting in the holding register. A frame followed by a queued byte does not set it.
- R6: Writing a 1 to status bit 6 clears transmit-complete. Writing 0 there has no effect. If the flag is cleared while the transmitter is idle, it stays 0 until another frame completes.
- R7: A pulse on `txc_ack_i` clears transmit-complete only while the completion interrupt is enabled. With the enable at 0, the acknowledge has no effect.
- R8: Transmitter-empty is a level flag. It is 1 whenever the shifter is idle and no byte is queued, whatever the history of the flags.
- R9: The receive-ready flag mirrors `rx_valid_i` in the same cycle.
- R10: Each interrupt output equals its flag ANDed with its enable bit in the control byte.
- R11: `de_o` is 1 when the RS485 enable bit is set and the transmitter is not empty. It falls in the same cycle that transmit-complete rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| baud_tick_i | input | 1 | Oversampling tick, 16 per bit |
| addr_i | input | 2 | Register address |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| rx_valid_i | input | 1 | External receive buffer holds unread data |
| txc_ack_i | input | 1 | Completion interrupt acknowledge |
| txd_o | output | 1 | Serial transmit line |
| de_o | output | 1 | RS485 driver enable |
| irq_txc_o | output | 1 | Transmit-complete interrupt request |
| irq_dre_o | output | 1 | Queue-ready interrupt request |
| irq_rxc_o | output | 1 | Receive-ready interrupt request |

## Verification
Every cycle, the assertions check these relations:
- The line stays high while the shifter is idle.
- A write that arrives while a byte is already queued leaves the holding register unchanged.
- Transmit-complete rises only after a shift ends with an empty queue.
- Transmit-complete falls only on a write-one-to-clear or an enabled acknowledge.
- The driver enable falls only together with a completion event.

Only the bench scenarios show that the bit order and the 16-tick bit length are right. They also show that back-to-back frames raise a single completion event, and that a cleared flag stays cleared through long idle time.

// File: rtl/uart_txc_pkg.sv
package uart_txc_pkg;
  localparam int unsigned REG_AW = 2;

  localparam logic [REG_AW-1:0] ADDR_DATA = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_STAT = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd2;

  localparam int unsigned ST_RXC = 7;
  localparam int unsigned ST_TXC = 6;
  localparam int unsigned ST_DRE = 5;
  localparam int unsigned ST_TXE = 4;

  typedef struct packed {
    logic [3:0] rsvd;
    logic       rs485_en;
    logic       rxc_ie;
    logic       dre_ie;
    logic       txc_ie;
  } ctrl_t;
endpackage

// File: rtl/uart_txc_hold.sv
module uart_txc_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (take_i) begin
      valid_o <= 1'b0;
    end else if (wr_i && !valid_o) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end
  end
endmodule

// File: rtl/uart_txc_shift.sv
module uart_txc_shift #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              txd_o,
  output logic              done_o
);
  localparam int unsigned FRAME_W = DATA_W + 2;
  localparam int unsigned IDX_W   = $clog2(FRAME_W);
  localparam int unsigned CNT_W   = $clog2(OVS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] frame_q;
  logic [IDX_W-1:0]   idx_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               bit_end;

  assign bit_end = busy_o && tick_i && (cnt_q == CNT_LAST);
  assign done_o  = bit_end && (idx_q == IDX_LAST);
  assign txd_o   = busy_o ? frame_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      frame_q <= '1;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else if (load_i) begin
      busy_o  <= 1'b1;
      frame_q <= {1'b1, data_i, 1'b0};
      idx_q   <= '0;
      cnt_q   <= '0;
    end else if (busy_o && tick_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (bit_end) begin
        cnt_q   <= '0;
        frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
        idx_q   <= idx_q + 1'b1;
        if (idx_q == IDX_LAST) busy_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_txc_flags.sv
module uart_txc_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_done_i,
  input  logic pending_i,
  input  logic w1c_i,
  input  logic ack_i,
  output logic txc_o
);
  logic set_evt;
  assign set_evt = frame_done_i && !pending_i;

  // a completion in the same cycle as a clear must not be lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                txc_o <= 1'b0;
    else if (set_evt)           txc_o <= 1'b1;
    else if (w1c_i || ack_i)    txc_o <= 1'b0;
  end
endmodule

// File: rtl/uart_txc_ctrl.sv
module uart_txc_ctrl
  import uart_txc_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              rx_valid_i,
  input  logic              txc_ack_i,
  output logic              txd_o,
  output logic              de_o,
  output logic              irq_txc_o,
  output logic              irq_dre_o,
  output logic              irq_rxc_o
);
  ctrl_t             ctrl_q;
  logic              wr_data, wr_stat, wr_ctrl;
  logic              hold_valid, busy, take, frame_done;
  logic [DATA_W-1:0] hold_data;
  logic              txc_q, dre, txe, w1c;

  assign wr_data = wr_en_i && (addr_i == ADDR_DATA);
  assign wr_stat = wr_en_i && (addr_i == ADDR_STAT);
  assign wr_ctrl = wr_en_i && (addr_i == ADDR_CTRL);
  assign w1c     = wr_stat && wdata_i[ST_TXC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'({4'b0, wdata_i[3:0]});
  end

  assign take = hold_valid && !busy;

  uart_txc_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_data),
    .data_i  (wdata_i[DATA_W-1:0]),
    .take_i  (take),
    .valid_o (hold_valid),
    .data_o  (hold_data)
  );

  uart_txc_shift #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (baud_tick_i),
    .load_i (take),
    .data_i (hold_data),
    .busy_o (busy),
    .txd_o  (txd_o),
    .done_o (frame_done)
  );

  uart_txc_flags u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_done_i (frame_done),
    .pending_i    (hold_valid),
    .w1c_i        (w1c),
    .ack_i        (txc_ack_i && ctrl_q.txc_ie),
    .txc_o        (txc_q)
  );

  assign dre  = !hold_valid;
  assign txe  = !hold_valid && !busy;
  assign de_o = ctrl_q.rs485_en && !txe;

  assign irq_txc_o = txc_q && ctrl_q.txc_ie;
  assign irq_dre_o = dre && ctrl_q.dre_ie;
  assign irq_rxc_o = rx_valid_i && ctrl_q.rxc_ie;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_STAT: begin
        rdata_o[ST_RXC] = rx_valid_i;
        rdata_o[ST_TXC] = txc_q;
        rdata_o[ST_DRE] = dre;
        rdata_o[ST_TXE] = txe;
      end
      ADDR_CTRL: rdata_o = ctrl_q;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/uart_txc_ctrl_chk.sv
module uart_txc_ctrl_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy,
  input logic              txd_o,
  input logic              hold_valid,
  input logic [DATA_W-1:0] hold_data,
  input logic              wr_data,
  input logic              txc_q,
  input logic              w1c,
  input logic              txc_ack_i,
  input logic              txc_ie,
  input logic              de_o,
  input logic              rs485_en
);
  p_idle_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> txd_o);

  p_full_ignore_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_valid && wr_data) |=> $stable(hold_data));

  p_txc_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(txc_q) |-> ($past(busy) && !busy && !hold_valid));

  p_txc_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(txc_q) |-> $past(w1c || (txc_ack_i && txc_ie)));

  p_de_release_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(de_o) && $stable(rs485_en)) |-> $rose(txc_q));
endmodule

bind uart_txc_ctrl uart_txc_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy       (busy),
  .txd_o      (txd_o),
  .hold_valid (hold_valid),
  .hold_data  (hold_data),
  .wr_data    (wr_data),
  .txc_q      (txc_q),
  .w1c        (w1c),
  .txc_ack_i  (txc_ack_i),
  .txc_ie     (ctrl_q.txc_ie),
  .de_o       (de_o),
  .rs485_en   (ctrl_q.rs485_en)
);

// File: tb/uart_txc_ctrl_tb.sv
module uart_txc_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic [1:0] addr = 2'd1;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rx_valid = 1'b0;
  logic       ack = 1'b0;
  logic       txd, de, irq_txc, irq_dre, irq_rxc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_txc_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick), .addr_i(addr),
    .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata), .rx_valid_i(rx_valid),
    .txc_ack_i(ack), .txd_o(txd), .de_o(de), .irq_txc_o(irq_txc),
    .irq_dre_o(irq_dre), .irq_rxc_o(irq_rxc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd1;
  endtask

  function automatic logic [7:0] stat();
    return {rdata[7:4], 4'b0};
  endfunction

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata; addr = 2'd1;
  endtask

  // receives one frame; returns at stop-bit centre (offset 152)
  task automatic rx_frame(output logic [7:0] b, input logic exp_de);
    logic [7:0] s;
    int n = 0;
    while (txd !== 1'b0 && n < 2000) begin @(negedge clk); n++; end
    repeat (8) @(negedge clk);
    check("R4 start bit", txd, 1'b0);
    for (int i = 0; i < 8; i++) begin
      repeat (16) @(negedge clk);
      b[i] = txd;
    end
    repeat (16) @(negedge clk);
    check("R4 stop bit", txd, 1'b1);
    check("R11 de during frame", de, exp_de);
    rd(2'd1, s);
    check("R5 txc low mid frame", s[6], 1'b0);
    check("R8 txe low mid frame", s[4], 1'b0);
  endtask

  task automatic t_reset();
    logic [7:0] s;
    rd(2'd1, s);
    check("R1 status after reset", s, 8'h30);
    rd(2'd2, s);
    check("R1 ctrl after reset", s, 8'h00);
    check("R1 txd idle", txd, 1'b1);
    check("R1 de idle", de, 1'b0);
    rd(2'd3, s);
    check("R2 unused address", s, 8'h00);
  endtask

  task automatic t_single();
    logic [7:0] b, s;
    wr(2'd2, 8'h08);
    rd(2'd2, s);
    check("R2 ctrl readback", s, 8'h08);
    wr(2'd0, 8'hA5);
    rd(2'd1, s);
    check("R3 dre low after write", s[5], 1'b0);
    @(negedge clk);
    rd(2'd1, s);
    check("R3 dre back after move", s[5], 1'b1);
    rx_frame(b, 1'b1);
    check("R4 data LSB first", b, 8'hA5);
    repeat (7) @(negedge clk);
    check("R11 de held to last tick", de, 1'b1);
    rd(2'd1, s);
    check("R5 txc not early", s[6], 1'b0);
    @(negedge clk);
    rd(2'd1, s);
    check("R5 txc set at end", s[6], 1'b1);
    check("R11 de drops with txc", de, 1'b0);
    check("R8 txe high when idle", s[4], 1'b1);
  endtask

  task automatic t_w1c();
    logic [7:0] s;
    wr(2'd1, 8'hBF);
    rd(2'd1, s);
    check("R6 write 0 keeps txc", s[6], 1'b1);
    wr(2'd1, 8'h40);
    rd(2'd1, s);
    check("R6 write 1 clears txc", s[6], 1'b0);
    repeat (60) @(negedge clk);
    rd(2'd1, s);
    check("R6 stays clear when idle", s[6], 1'b0);
    check("R8 txe regardless of txc", s[4], 1'b1);
    check("R4 line idle high", txd, 1'b1);
  endtask

  task automatic t_b2b();
    logic [7:0] b, s;
    wr(2'd0, 8'h3C);
    @(negedge clk);
    wr(2'd0, 8'hC3);
    rd(2'd1, s);
    check("R3 dre low while queued", s[5], 1'b0);
    wr(2'd0, 8'hFF);
    rx_frame(b, 1'b1);
    check("R4 first byte", b, 8'h3C);
    rx_frame(b, 1'b1);
    check("R3 queued byte kept, extra ignored", b, 8'hC3);
    repeat (8) @(negedge clk);
    rd(2'd1, s);
    check("R5 txc after last frame", s[6], 1'b1);
    repeat (200) @(negedge clk);
    check("R3 no third frame", txd, 1'b1);
  endtask

  task automatic t_ack();
    logic [7:0] s;
    wr(2'd2, 8'h00);
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    rd(2'd1, s);
    check("R7 ack ignored without enable", s[6], 1'b1);
    check("R10 irq_txc gated off", irq_txc, 1'b0);
    wr(2'd2, 8'h01);
    check("R10 irq_txc follows flag", irq_txc, 1'b1);
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    rd(2'd1, s);
    check("R7 ack clears txc", s[6], 1'b0);
    check("R10 irq_txc drops", irq_txc, 1'b0);
  endtask

  task automatic t_rx_irq();
    logic [7:0] s;
    wr(2'd2, 8'h06);
    check("R10 irq_dre when empty", irq_dre, 1'b1);
    check("R10 irq_rxc idle", irq_rxc, 1'b0);
    rx_valid = 1'b1; #1;
    rd(2'd1, s);
    check("R9 rx flag set", s[7], 1'b1);
    check("R10 irq_rxc", irq_rxc, 1'b1);
    rx_valid = 1'b0; #1;
    rd(2'd1, s);
    check("R9 rx flag clear", s[7], 1'b0);
    @(negedge clk);
  endtask

  task automatic t_no_rs485();
    logic [7:0] b;
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h5A);
    rx_frame(b, 1'b0);
    check("R4 byte without rs485", b, 8'h5A);
    repeat (8) @(negedge clk);
    check("R11 de stays low", de, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_w1c();
    t_b2b();
    t_ack();
    t_rx_irq();
    t_no_rs485();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule